// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a 16-bit physical address by way of a four-entry segment table. The two most significant address bits pick a table entry and the twelve remaining bits are an offset into that segment. Each entry holds a base, a bound, a valid flag and a read-only flag. The adder that forms base plus offset and the comparator that tests the offset against the bound work side by side in one combinational stage. The response is captured in a register one cycle after the request.

Table entries are loaded through a configuration write port. A write takes effect only while the privilege input is high. When a request breaks a rule, the unit returns a two-bit fault cause and no address. The table describes one address space at a time, so a context switch means rewriting the entries.

Top module: `seg_xlate`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` is 0 and every segment is invalid, so any request to any segment answers with fault code 01.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high at the clock edge, and low otherwise.
- R3: With no fault, `rsp_fault` is 00 and `rsp_paddr` is (segment base + zero-extended offset) modulo 2^16, where the segment is `req_addr[13:12]` and the offset is `req_addr[11:0]`.
- R4: A request to a segment whose valid flag is 0 answers with fault 01 and `rsp_paddr` 0.
- R5: A request whose offset is greater than or equal to the segment bound (13 bits, 0 to 4096) answers with fault 10 and `rsp_paddr` 0. A bound of 0 blocks every offset and a bound of 4096 admits every offset.
- R6: A write request (`req_write`=1) to a read-only segment answers with fault 11 and `rsp_paddr` 0. A read of the same segment translates normally.
- R7: When several rules are broken, the fault reported is the first in this order: invalid (01), out of bound (10), write to read-only (11).
- R8: A configuration write with `cfg_priv` low changes no table entry.
- R9: A privileged configuration write changes only the entry selected by `cfg_seg`. The other entries keep their contents.
- R10: A request in the same cycle as a configuration write is translated with the table contents from before that write.
- R11: In any cycle with `rsp_valid` low, `rsp_paddr` and `rsp_fault` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privilege qualifier for the configuration write |
| cfg_seg | input | 2 | Table entry to write |
| cfg_base | input | 16 | Segment base physical address |
| cfg_bound | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_valid | input | 1 | Segment valid flag |
| cfg_ro | input | 1 | Segment read-only flag |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 14 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| rsp_fault | output | 2 | Fault cause: 00 none, 01 invalid, 10 bound, 11 read-only |

## Verification
A corrupt table entry, such as a base, bound or flag that is wrong or that leaked in from an unprivileged or misdirected write, stays hidden until a request targets that segment. It then shows up in the very next response as a wrong address or a wrong fault code. The bench therefore sends requests to every segment after each configuration change, so a bad entry is seen within a few cycles. A fault in the response register shows up in the same cycle, as a strobe that is missing or extra, or as non-zero data while idle.

// File: rtl/seg_xlate_pkg.sv
// Package: shared fault-cause encoding for the segment translation unit.
// Assumes two bits are enough for the four outcomes.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_BOUND   = 2'b10,
        FLT_RDONLY  = 2'b11
    } fault_e;
endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds one base/bound/valid/read-only entry per segment.
// Writes are qualified by a privilege input. The read port is combinational,
// so a same-cycle reader sees the contents from before the write.
// Assumes synchronous active-low reset, which clears every entry.
module seg_table #(
    parameter int SEG_W = 2,
    parameter int PA_W  = 16,
    parameter int BND_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [SEG_W-1:0] wr_sel,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [BND_W-1:0] wr_bound,
    input  logic             wr_valid,
    input  logic             wr_ro,
    input  logic [SEG_W-1:0] rd_sel,
    output logic [PA_W-1:0]  rd_base,
    output logic [BND_W-1:0] rd_bound,
    output logic             rd_valid,
    output logic             rd_ro
);
    localparam int NSEG = 1 << SEG_W;

    logic [NSEG-1:0][PA_W-1:0]  base_q;
    logic [NSEG-1:0][BND_W-1:0] bound_q;
    logic [NSEG-1:0]            valid_q;
    logic [NSEG-1:0]            ro_q;
    logic                       wr_ok;

    assign wr_ok = wr_en && wr_priv;

    for (genvar k = 0; k < NSEG; k++) begin : g_entry
        // Purpose: load entry k on a privileged write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[k]  <= '0;
                bound_q[k] <= '0;
                valid_q[k] <= 1'b0;
                ro_q[k]    <= 1'b0;
            end else if (wr_ok && wr_sel == SEG_W'(k)) begin
                base_q[k]  <= wr_base;
                bound_q[k] <= wr_bound;
                valid_q[k] <= wr_valid;
                ro_q[k]    <= wr_ro;
            end
        end

        // R9: an entry that is not the target of a privileged write holds.
        assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_ok && wr_sel == SEG_W'(k)) |=>
                ($stable(base_q[k]) && $stable(bound_q[k]) &&
                 $stable(valid_q[k]) && $stable(ro_q[k])));
    end

    // Purpose: combinational read of the selected entry.
    always_comb begin
        rd_base  = base_q[rd_sel];
        rd_bound = bound_q[rd_sel];
        rd_valid = valid_q[rd_sel];
        rd_ro    = ro_q[rd_sel];
    end

    // R8: without privilege the whole table stays unchanged.
    assert_unpriv_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=>
            ($stable(base_q) && $stable(bound_q) && $stable(valid_q) && $stable(ro_q)));
endmodule

// File: rtl/seg_check.sv
// Module: seg_check
// Combinational translate-and-check. The base adder and the bound comparator
// run side by side, and a priority pick chooses the fault cause.
// Assumes PA_W > OFF_W and BND_W = OFF_W + 1.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int BND_W = 13
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    input  logic [PA_W-1:0]  base,
    input  logic [BND_W-1:0] bound,
    input  logic             seg_valid,
    input  logic             seg_ro,
    output logic [PA_W-1:0]  paddr,
    output fault_e           fault
);
    logic in_range;

    // Purpose: relocation sum, wrapping modulo 2^PA_W.
    always_comb paddr = base + {{(PA_W-OFF_W){1'b0}}, offset};

    // Purpose: bound test in parallel with the adder.
    always_comb in_range = {{(BND_W-OFF_W){1'b0}}, offset} < bound;

    // Purpose: pick the fault in priority order invalid, bound, read-only.
    always_comb begin
        if (!seg_valid)              fault = FLT_INVALID;
        else if (!in_range)          fault = FLT_BOUND;
        else if (is_write && seg_ro) fault = FLT_RDONLY;
        else                         fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Splits the virtual address into segment and offset, reads the table,
// translates and checks, and registers the response one cycle later.
// Assumes synchronous active-low reset. Data outputs are zero while idle
// and on a fault.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int SEG_W = 2,
    parameter int PA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_priv,
    input  logic [SEG_W-1:0]          cfg_seg,
    input  logic [PA_W-1:0]           cfg_base,
    input  logic [VA_W-SEG_W:0]       cfg_bound,
    input  logic                      cfg_valid,
    input  logic                      cfg_ro,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_addr,
    input  logic                      req_write,
    output logic                      rsp_valid,
    output logic [PA_W-1:0]           rsp_paddr,
    output logic [1:0]                rsp_fault
);
    localparam int OFF_W = VA_W - SEG_W;
    localparam int BND_W = OFF_W + 1;

    logic [SEG_W-1:0] seg_sel;
    logic [OFF_W-1:0] offset;
    logic [PA_W-1:0]  ent_base;
    logic [BND_W-1:0] ent_bound;
    logic             ent_valid;
    logic             ent_ro;
    logic [PA_W-1:0]  xl_paddr;
    fault_e           xl_fault;

    // Purpose: carve segment number from the top and offset from the bottom.
    always_comb begin
        seg_sel = req_addr[VA_W-1:OFF_W];
        offset  = req_addr[OFF_W-1:0];
    end

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_priv  (cfg_priv),
        .wr_sel   (cfg_seg),
        .wr_base  (cfg_base),
        .wr_bound (cfg_bound),
        .wr_valid (cfg_valid),
        .wr_ro    (cfg_ro),
        .rd_sel   (seg_sel),
        .rd_base  (ent_base),
        .rd_bound (ent_bound),
        .rd_valid (ent_valid),
        .rd_ro    (ent_ro)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .BND_W(BND_W)) u_check (
        .offset    (offset),
        .is_write  (req_write),
        .base      (ent_base),
        .bound     (ent_bound),
        .seg_valid (ent_valid),
        .seg_ro    (ent_ro),
        .paddr     (xl_paddr),
        .fault     (xl_fault)
    );

    // Purpose: register the response, zeroing the address on a fault or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 2'b00;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= xl_fault;
                rsp_paddr <= (xl_fault == FLT_NONE) ? xl_paddr : '0;
            end else begin
                rsp_fault <= 2'b00;
                rsp_paddr <= '0;
            end
        end
    end

    // R2: one response per request, in the next cycle.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: a faulting response carries no address.
    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);
    // R6: a load never reports the read-only fault.
    assert_load_not_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_fault != 2'b11);
    // R11: idle outputs are zero.
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'b00));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0, cfg_ro = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_bound = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model of the table
    logic [15:0] m_base [4];
    logic [12:0] m_bound[4];
    logic        m_valid[4];
    logic        m_ro   [4];

    // expected response pending from the previous cycle
    bit          p_have = 0;
    logic        p_valid;
    logic [15:0] p_paddr;
    logic [1:0]  p_fault;
    string       p_tag;

    always #5 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_seg(cfg_seg),
        .cfg_base(cfg_base), .cfg_bound(cfg_bound), .cfg_valid(cfg_valid), .cfg_ro(cfg_ro),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [1:0] exp_fault(logic [13:0] a, logic wr);
        int s = int'(a[13:12]);
        if (!m_valid[s])                          return 2'b01;
        if ({1'b0, a[11:0]} >= m_bound[s])        return 2'b10;
        if (wr && m_ro[s])                        return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [15:0] exp_paddr(logic [13:0] a, logic wr);
        if (exp_fault(a, wr) != 2'b00) return 16'h0;
        return m_base[int'(a[13:12])] + {4'h0, a[11:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (!p_have) return;
        chk({p_tag, " valid"}, {31'h0, rsp_valid}, {31'h0, p_valid});
        chk({p_tag, " paddr"}, {16'h0, rsp_paddr}, {16'h0, p_paddr});
        chk({p_tag, " fault"}, {30'h0, rsp_fault}, {30'h0, p_fault});
        p_have = 0;
    endtask

    // One clock: check the previous response, drive inputs, predict, update model.
    task automatic cycle(logic cw, logic cp, logic [1:0] cs, logic [15:0] cb,
                         logic [12:0] cbd, logic cv, logic cr,
                         logic rv, logic [13:0] ra, logic rw, string tag);
        @(negedge clk);
        check_pending();
        cfg_we = cw; cfg_priv = cp; cfg_seg = cs; cfg_base = cb;
        cfg_bound = cbd; cfg_valid = cv; cfg_ro = cr;
        req_valid = rv; req_addr = ra; req_write = rw;
        p_have  = 1;
        p_valid = rv;
        p_paddr = rv ? exp_paddr(ra, rw) : 16'h0;
        p_fault = rv ? exp_fault(ra, rw) : 2'b00;
        if (tag != "") p_tag = tag;
        else if (!rv) p_tag = "R11";
        else case (p_fault)
            2'b00:   p_tag = "R3";
            2'b01:   p_tag = "R4";
            2'b10:   p_tag = "R5";
            default: p_tag = "R6";
        endcase
        if (cw && cp) begin
            m_base[int'(cs)] = cb; m_bound[int'(cs)] = cbd;
            m_valid[int'(cs)] = cv; m_ro[int'(cs)] = cr;
        end
    endtask

    task automatic cfg(logic p, logic [1:0] s, logic [15:0] b, logic [12:0] bd,
                       logic v, logic r);
        cycle(1'b1, p, s, b, bd, v, r, 1'b0, 14'h0, 1'b0, "");
    endtask

    task automatic req(logic [13:0] a, logic w, string tag);
        cycle(1'b0, 1'b0, 2'b0, 16'h0, 13'h0, 1'b0, 1'b0, 1'b1, a, w, tag);
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_bound[i] = '0; m_valid[i] = 0; m_ro[i] = 0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        chk("R1 rsp_paddr after reset", {16'h0, rsp_paddr}, 32'h0);
        chk("R1 rsp_fault after reset", {30'h0, rsp_fault}, 32'h0);
        req(14'h2123, 1'b0, "R1 seg2 invalid after reset");
        req(14'h0000, 1'b1, "R1 seg0 invalid after reset");
        // R8: unprivileged write is dropped
        cfg(1'b0, 2'd1, 16'h0100, 13'h040, 1'b1, 1'b0);
        req(14'h1000, 1'b0, "R8 unprivileged write ignored");
        // R3 and R5 boundary cases on segment 1
        cfg(1'b1, 2'd1, 16'h2000, 13'h040, 1'b1, 1'b0);
        req(14'h103F, 1'b0, "R3 last legal offset");
        req(14'h1040, 1'b0, "R5 offset equal to bound");
        cfg(1'b1, 2'd2, 16'h4000, 13'h000, 1'b1, 1'b0);
        req(14'h2000, 1'b0, "R5 zero bound blocks offset 0");
        cfg(1'b1, 2'd3, 16'hFFF0, 13'h1000, 1'b1, 1'b1);
        req(14'h3FFF, 1'b0, "R5 full bound admits max offset, R3 wraps");
        req(14'h3005, 1'b1, "R6 store to read-only");
        req(14'h3005, 1'b0, "R6 load from read-only");
        // R7 priority
        cfg(1'b1, 2'd2, 16'h4000, 13'h010, 1'b1, 1'b1);
        req(14'h2020, 1'b1, "R7 bound beats read-only");
        cfg(1'b1, 2'd0, 16'h1234, 13'h000, 1'b0, 1'b1);
        req(14'h0020, 1'b1, "R7 invalid beats bound and read-only");
        // R10 same-cycle write and request
        cycle(1'b1, 1'b1, 2'd1, 16'h0, 13'h0, 1'b0, 1'b0, 1'b1, 14'h1004, 1'b0,
              "R10 request sees old entry");
        req(14'h1004, 1'b0, "R10 next request sees new entry");
        // R9 other entry untouched
        req(14'h3010, 1'b0, "R9 segment 3 unchanged");
        // R2 / R11 idle cycle
        cycle(1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 1'b0, 1'b0, 1'b0, 14'h0, 1'b0,
              "R2 R11 idle cycle");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic        cw = ($urandom % 4) == 0;
            logic        cp = ($urandom % 4) != 0;
            logic [12:0] bd;
            logic [13:0] a = 14'($urandom);
            int          sel = int'($urandom % 4);
            if (sel == 0)      bd = 13'h0;
            else if (sel == 1) bd = 13'h1000;
            else               bd = 13'($urandom % 4097);
            if (($urandom % 3) == 0) begin
                logic [12:0] b2 = m_bound[int'(a[13:12])];
                logic [11:0] near = (b2 == 0) ? 12'h0 : 12'(b2 - 13'(($urandom % 2)));
                a[11:0] = near;
            end
            cycle(cw, cp, 2'($urandom), 16'($urandom), bd,
                  ($urandom % 5) != 0, 1'($urandom),
                  ($urandom % 4) != 0, a, 1'($urandom), "");
        end
        @(negedge clk);
        check_pending();
        finish_up();
    end
endmodule